// File: doc/BRIEF.md
# Predicated Move Element Sequencer

This controller turns one register move instruction into a sequence of element transfers over a register file that is stored elsewhere. The source and the destination are each either a single register (scalar) or a run of consecutive registers that starts at a base register (vector). Either vector side may also carry a predicate mask. The same move then acts as one of several operations. It can be a broadcast, a masked broadcast, a single-element insert, an extract, a straight copy, a packing or unpacking copy, or a gather/scatter. Which one it is depends only on these settings.

A start pulse latches the whole configuration. From the next cycle on, the sequencer takes one step per cycle. A step either issues one read/write register pair on its output or skips an element whose predicate bit is clear. A one-cycle done pulse ends the operation, and in that same cycle the block is idle again. The caller performs the data movement for each issued pair. Data width and storage are outside this block.

Top module: `pmove_seq`

## Requirements
- R1: After reset, busy_o, xfer_valid_o and done_o are all low.
- R2: A start_i pulse seen while busy_o is low is accepted at that edge, and busy_o is high in the next cycle with no transfer and no done. A start_i seen while busy_o is high is ignored, and so are any input changes made with it. The operation in flight runs on unchanged.
- R3: The block takes one step per cycle. The result of step n (n = 1, 2, ...) appears n cycles after the accepting edge. A step issues at most one pair on xfer_valid_o/xfer_src_o/xfer_dst_o.
- R4: Splat: a scalar source with a vector destination and no destination predicate writes destination elements 0 to VL-1 in order. Every pair reads the source base register.
- R5: Sparse splat and insert: with a destination predicate enabled, pairs are issued only for destination elements whose mask bit is 1. Bit i of a mask belongs to element i, with the LSB as element 0. A mask with exactly one set bit gives exactly one pair.
- R6: Extract: a vector source with a scalar destination moves only the lowest-indexed source element whose predicate bit is set, or element 0 when no source predicate is enabled, and then ends. With no set bit below VL, no pair is issued.
- R7: Copy: vector to vector with no predicates pairs source element i with destination element i for i = 0 to VL-1.
- R8: Sparse copy: when only one vector side is predicated, its set elements, taken in ascending order, are paired with consecutive elements of the other side starting at 0.
- R9: Gather/scatter: with both sides predicated, the k-th set source element is paired with the k-th set destination element. The operation ends as soon as either index reaches VL.
- R10: done_o is high for exactly one cycle. In that cycle busy_o is low and no pair is issued, and busy_o never falls without done_o.
- R11: A predicate enable on a scalar side has no effect. With a vector side and VL = 0, done comes with no pair. A VL above VMAX is treated as VMAX.
- R12: Register numbers are base plus element index modulo NREG.
- R13: A scalar-to-scalar move issues exactly one pair (source base, destination base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| src_base_i | input | RW | Source base register number |
| dst_base_i | input | RW | Destination base register number |
| src_vec_i | input | 1 | 1 = source is a vector |
| dst_vec_i | input | 1 | 1 = destination is a vector |
| vlen_i | input | LW | Vector length in elements |
| src_pred_en_i | input | 1 | Enable the source predicate |
| src_pred_i | input | VMAX | Source predicate mask, bit i = element i |
| dst_pred_en_i | input | 1 | Enable the destination predicate |
| dst_pred_i | input | VMAX | Destination predicate mask, bit i = element i |
| busy_o | output | 1 | Operation in progress |
| xfer_valid_o | output | 1 | A register pair is issued this cycle |
| xfer_src_o | output | RW | Register to read |
| xfer_dst_o | output | RW | Register to write |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
busy_o is due one cycle after the accepting edge. The outcome of step n, which is a pair, a skip or done, is due n cycles after that edge. The bench's behavioural model therefore produces one expected entry per cycle for each operation. The bench drives inputs on falling edges and compares every output on each following falling edge, walking the expected list cycle by cycle. For the main modes it also compares the collected pairs against hand-worked lists.

// File: rtl/pmove_pkg.sv
package pmove_pkg;

  typedef enum logic [2:0] {
    MV_SCALAR       = 3'd0,
    MV_SPLAT        = 3'd1,
    MV_SPARSE_SPLAT = 3'd2,
    MV_EXTRACT      = 3'd3,
    MV_COPY         = 3'd4,
    MV_SPARSE_COPY  = 3'd5,
    MV_GATHER       = 3'd6
  } mv_kind_e;

  function automatic logic kind_is_single(input mv_kind_e k);
    return (k == MV_SCALAR) || (k == MV_EXTRACT);
  endfunction

endpackage

// File: rtl/pmove_kind_dec.sv
module pmove_kind_dec
  import pmove_pkg::*;
(
  input  logic     src_vec_i,
  input  logic     dst_vec_i,
  input  logic     src_pen_i,
  input  logic     dst_pen_i,
  output mv_kind_e kind_o,
  output logic     single_o
);
  logic sp_on, dp_on;

  assign sp_on = src_vec_i && src_pen_i;
  assign dp_on = dst_vec_i && dst_pen_i;

  always_comb begin
    unique case ({src_vec_i, dst_vec_i})
      2'b00:   kind_o = MV_SCALAR;
      2'b01:   kind_o = dp_on ? MV_SPARSE_SPLAT : MV_SPLAT;
      2'b10:   kind_o = MV_EXTRACT;
      default: kind_o = (sp_on && dp_on) ? MV_GATHER :
                        (sp_on || dp_on) ? MV_SPARSE_COPY : MV_COPY;
    endcase
  end

  assign single_o = kind_is_single(kind_o);
endmodule

// File: rtl/pmove_lane.sv
module pmove_lane #(
  parameter int VMAX = 16,
  parameter int RW   = 5,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic            vec_i,
  input  logic            pen_i,
  input  logic [VMAX-1:0] mask_i,
  input  logic [RW-1:0]   base_i,
  input  logic [LW-1:0]   vl_i,
  output logic [RW-1:0]   addr_o,
  output logic            ok_o,
  output logic            end_o
);
  localparam int SW = (VMAX > 1) ? $clog2(VMAX) : 1;

  logic [LW-1:0] idx_q;
  logic          in_range;
  logic          bit_sel;
  logic [RW-1:0] offset;

  always_ff @(posedge clk) begin
    if (rst)                idx_q <= '0;
    else if (load_i)        idx_q <= '0;
    else if (adv_i && vec_i) idx_q <= idx_q + LW'(1);
  end

  assign in_range = (idx_q < LW'(VMAX));
  assign bit_sel  = in_range ? mask_i[idx_q[SW-1:0]] : 1'b0;
  assign end_o    = vec_i && (idx_q >= vl_i);
  assign ok_o     = !(vec_i && pen_i) || bit_sel;
  assign offset   = vec_i ? RW'(idx_q) : '0;
  assign addr_o   = base_i + offset;
endmodule

// File: rtl/pmove_step.sv
module pmove_step (
  input  logic stop_i,
  input  logic single_i,
  input  logic s_ok_i,
  input  logic d_ok_i,
  input  logic s_end_i,
  input  logic d_end_i,
  output logic xfer_o,
  output logic adv_s_o,
  output logic adv_d_o,
  output logic finish_o,
  output logic stop_set_o
);
  always_comb begin
    xfer_o     = 1'b0;
    adv_s_o    = 1'b0;
    adv_d_o    = 1'b0;
    stop_set_o = 1'b0;
    finish_o   = stop_i || s_end_i || d_end_i;
    if (!finish_o) begin
      if (s_ok_i && d_ok_i) begin
        xfer_o     = 1'b1;
        adv_s_o    = 1'b1;
        adv_d_o    = 1'b1;
        stop_set_o = single_i;
      end else begin
        adv_s_o = !s_ok_i;
        adv_d_o = !d_ok_i;
      end
    end
  end
endmodule

// File: rtl/pmove_seq.sv
module pmove_seq
  import pmove_pkg::*;
#(
  parameter int NREG = 32,
  parameter int VMAX = 16,
  localparam int RW  = $clog2(NREG),
  localparam int LW  = $clog2(VMAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [RW-1:0]   src_base_i,
  input  logic [RW-1:0]   dst_base_i,
  input  logic            src_vec_i,
  input  logic            dst_vec_i,
  input  logic [LW-1:0]   vlen_i,
  input  logic            src_pred_en_i,
  input  logic [VMAX-1:0] src_pred_i,
  input  logic            dst_pred_en_i,
  input  logic [VMAX-1:0] dst_pred_i,
  output logic            busy_o,
  output logic            xfer_valid_o,
  output logic [RW-1:0]   xfer_src_o,
  output logic [RW-1:0]   xfer_dst_o,
  output logic            done_o
);
  // side 0 = source, side 1 = destination
  logic            run_q, stop_q;
  logic [1:0]      vec_q, pen_q;
  logic [RW-1:0]   base_q [2];
  logic [VMAX-1:0] mask_q [2];
  logic [LW-1:0]   vl_q;
  logic            accept;

  logic [RW-1:0]   addr_w [2];
  logic [1:0]      ok_w, end_w, adv_w;
  mv_kind_e        kind;
  logic            single;
  logic            do_xfer, finish, stop_set;

  assign accept = start_i && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q     <= '0;
      pen_q     <= '0;
      base_q[0] <= '0;
      base_q[1] <= '0;
      mask_q[0] <= '0;
      mask_q[1] <= '0;
      vl_q      <= '0;
    end else if (accept) begin
      vec_q     <= {dst_vec_i, src_vec_i};
      pen_q     <= {dst_pred_en_i, src_pred_en_i};
      base_q[0] <= src_base_i;
      base_q[1] <= dst_base_i;
      mask_q[0] <= src_pred_i;
      mask_q[1] <= dst_pred_i;
      vl_q      <= (vlen_i > LW'(VMAX)) ? LW'(VMAX) : vlen_i;
    end
  end

  pmove_kind_dec u_dec (
    .src_vec_i (vec_q[0]),
    .dst_vec_i (vec_q[1]),
    .src_pen_i (pen_q[0]),
    .dst_pen_i (pen_q[1]),
    .kind_o    (kind),
    .single_o  (single)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    pmove_lane #(.VMAX(VMAX), .RW(RW), .LW(LW)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load_i (accept),
      .adv_i  (run_q && adv_w[g]),
      .vec_i  (vec_q[g]),
      .pen_i  (pen_q[g]),
      .mask_i (mask_q[g]),
      .base_i (base_q[g]),
      .vl_i   (vl_q),
      .addr_o (addr_w[g]),
      .ok_o   (ok_w[g]),
      .end_o  (end_w[g])
    );
  end

  pmove_step u_step (
    .stop_i     (stop_q),
    .single_i   (single),
    .s_ok_i     (ok_w[0]),
    .d_ok_i     (ok_w[1]),
    .s_end_i    (end_w[0]),
    .d_end_i    (end_w[1]),
    .xfer_o     (do_xfer),
    .adv_s_o    (adv_w[0]),
    .adv_d_o    (adv_w[1]),
    .finish_o   (finish),
    .stop_set_o (stop_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q        <= 1'b0;
      stop_q       <= 1'b0;
      xfer_valid_o <= 1'b0;
      xfer_src_o   <= '0;
      xfer_dst_o   <= '0;
      done_o       <= 1'b0;
    end else if (!run_q) begin
      xfer_valid_o <= 1'b0;
      done_o       <= 1'b0;
      if (accept) begin
        run_q  <= 1'b1;
        stop_q <= 1'b0;
      end
    end else begin
      xfer_valid_o <= do_xfer;
      done_o       <= finish;
      if (do_xfer) begin
        xfer_src_o <= addr_w[0];
        xfer_dst_o <= addr_w[1];
      end
      if (stop_set) stop_q <= 1'b1;
      if (finish)   run_q  <= 1'b0;
    end
  end

  assign busy_o = run_q;
endmodule

// File: rtl/pmove_seq_chk.sv
module pmove_seq_chk
  import pmove_pkg::*;
#(
  parameter int VMAX = 16,
  parameter int RW   = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          xfer_valid_o,
  input logic          done_o,
  input logic [RW-1:0] xfer_src_o,
  input logic [RW-1:0] src_base_q,
  input logic          src_vec_q,
  input mv_kind_e      kind
);
  int run_len;
  int xfer_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) begin
      run_len  <= 0;
      xfer_cnt <= 0;
    end else begin
      run_len <= run_len + 1;
      if (xfer_valid_o) xfer_cnt <= xfer_cnt + 1;
    end
  end

  AST_XFER_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o |-> busy_o);                                           // R3
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (run_len <= 2 * VMAX + 2));                              // R3
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);                                   // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !xfer_valid_o));                             // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);                                                // R10
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);                                          // R10
  AST_SCALAR_SRC_FIXED: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && !src_vec_q) |-> (xfer_src_o == src_base_q));      // R4
  AST_SINGLE_XFER: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid_o && kind_is_single(kind)) |-> (xfer_cnt == 0));       // R6
endmodule

bind pmove_seq pmove_seq_chk #(.VMAX(VMAX), .RW(RW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .xfer_valid_o (xfer_valid_o),
  .done_o       (done_o),
  .xfer_src_o   (xfer_src_o),
  .src_base_q   (base_q[0]),
  .src_vec_q    (vec_q[0]),
  .kind         (kind)
);

// File: tb/pmove_seq_tb.sv
module pmove_seq_tb;
  localparam int NREG = 32;
  localparam int VMAX = 16;
  localparam int RW   = $clog2(NREG);
  localparam int LW   = $clog2(VMAX + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic [RW-1:0]   src_base_i = '0, dst_base_i = '0;
  logic            src_vec_i = 1'b0, dst_vec_i = 1'b0;
  logic [LW-1:0]   vlen_i = '0;
  logic            src_pred_en_i = 1'b0, dst_pred_en_i = 1'b0;
  logic [VMAX-1:0] src_pred_i = '0, dst_pred_i = '0;
  logic            busy_o, xfer_valid_o, done_o;
  logic [RW-1:0]   xfer_src_o, xfer_dst_o;

  pmove_seq #(.NREG(NREG), .VMAX(VMAX)) u_dut (.*);

  always #4 clk = ~clk;

  typedef struct { bit v; int s; int d; bit dn; } ent_t;
  ent_t exp_q[$];
  int   log_s[$], log_d[$], hand_s[$], hand_d[$];
  int   errors = 0, checks = 0, cycles = 0;
  bit   finished = 0;

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got cycles=%0d, want fewer", cycles);
      report();
    end
  end

  task automatic chk(string tag, bit ok, string got, string want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %s, want %s", tag, got, want);
    end
  endtask

  // Behavioural reference: one expected entry per cycle after the accepting edge.
  task automatic build_model(bit sv, bit dv, bit spe, bit dpe,
                             logic [VMAX-1:0] sm, logic [VMAX-1:0] dm,
                             int sb, int db, int vl);
    int vle = (vl > VMAX) ? VMAX : vl;
    int si = 0, di = 0;
    bit stop = 0;
    bit one = !dv;
    exp_q.delete();
    for (int n = 0; n < 4 * VMAX + 4; n++) begin
      bit so, dok;
      if (stop || (sv && si >= vle) || (dv && di >= vle)) begin
        exp_q.push_back('{v: 0, s: 0, d: 0, dn: 1});
        break;
      end
      so  = !(sv && spe) || sm[si];
      dok = !(dv && dpe) || dm[di];
      if (so && dok) begin
        exp_q.push_back('{v: 1, s: (sb + (sv ? si : 0)) % NREG,
                          d: (db + (dv ? di : 0)) % NREG, dn: 0});
        if (sv) si++;
        if (dv) di++;
        if (one) stop = 1;
      end else begin
        exp_q.push_back('{v: 0, s: 0, d: 0, dn: 0});
        if (!so) si++;
        if (!dok) di++;
      end
    end
  endtask

  task automatic run_op(string tag, bit sv, bit dv, bit spe, bit dpe,
                        logic [VMAX-1:0] sm, logic [VMAX-1:0] dm,
                        int sb, int db, int vl, bit poke);
    build_model(sv, dv, spe, dpe, sm, dm, sb, db, vl);
    log_s.delete(); log_d.delete();
    @(negedge clk);
    src_vec_i = sv; dst_vec_i = dv; src_pred_en_i = spe; dst_pred_en_i = dpe;
    src_pred_i = sm; dst_pred_i = dm;
    src_base_i = RW'(sb); dst_base_i = RW'(db); vlen_i = LW'(vl);
    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R2 accept"}, busy_o && !xfer_valid_o && !done_o,
        $sformatf("busy=%0b v=%0b done=%0b", busy_o, xfer_valid_o, done_o),
        "busy=1 v=0 done=0");
    for (int k = 0; k < exp_q.size(); k++) begin
      if (poke && k == 0) begin
        // R2: start while busy with altered inputs must be ignored
        start_i = 1'b1; src_base_i = RW'(sb + 5); dst_base_i = RW'(db + 7);
        src_vec_i = !sv; vlen_i = '0;
      end
      @(posedge clk); @(negedge clk);
      if (poke && k == 0) start_i = 1'b0;
      chk($sformatf("%s R3 step %0d", tag, k + 1),
          xfer_valid_o == exp_q[k].v && done_o == exp_q[k].dn &&
          busy_o == !exp_q[k].dn &&
          (!exp_q[k].v || (int'(xfer_src_o) == exp_q[k].s &&
                           int'(xfer_dst_o) == exp_q[k].d)),
          $sformatf("v=%0b s=%0d d=%0d done=%0b busy=%0b", xfer_valid_o,
                    xfer_src_o, xfer_dst_o, done_o, busy_o),
          $sformatf("v=%0b s=%0d d=%0d done=%0b busy=%0b", exp_q[k].v,
                    exp_q[k].s, exp_q[k].d, exp_q[k].dn, !exp_q[k].dn));
      if (xfer_valid_o) begin
        log_s.push_back(int'(xfer_src_o));
        log_d.push_back(int'(xfer_dst_o));
      end
    end
  endtask

  task automatic want(int s, int d);
    hand_s.push_back(s); hand_d.push_back(d);
  endtask

  task automatic check_hand(string tag);
    bit ok = (log_s.size() == hand_s.size());
    if (ok) foreach (hand_s[i])
      if (log_s[i] != hand_s[i] || log_d[i] != hand_d[i]) ok = 0;
    chk({tag, " pair list"}, ok, $sformatf("%p -> %p", log_s, log_d),
        $sformatf("%p -> %p", hand_s, hand_d));
    hand_s.delete(); hand_d.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", !busy_o && !xfer_valid_o && !done_o,
        $sformatf("busy=%0b v=%0b done=%0b", busy_o, xfer_valid_o, done_o), "all 0");
    rst = 1'b0;

    // R4 splat
    run_op("R4", 0, 1, 0, 0, '0, '0, 3, 8, 4, 0);
    want(3, 8); want(3, 9); want(3, 10); want(3, 11); check_hand("R4");
    // R5 sparse splat and insert
    run_op("R5", 0, 1, 0, 1, '0, 16'b1010, 3, 8, 4, 0);
    want(3, 9); want(3, 11); check_hand("R5");
    run_op("R5 insert", 0, 1, 0, 1, '0, 16'b0100, 3, 8, 8, 0);
    want(3, 10); check_hand("R5 insert");
    // R6 extract, with and without a set bit
    run_op("R6", 1, 0, 1, 0, 16'b0110_0000, '0, 4, 20, 8, 0);
    want(9, 20); check_hand("R6");
    run_op("R6 none", 1, 0, 1, 0, 16'h0100, '0, 4, 20, 8, 0);
    check_hand("R6 none");
    run_op("R6 nopred", 1, 0, 0, 0, '0, '0, 4, 20, 8, 0);
    want(4, 20); check_hand("R6 nopred");
    // R7 copy
    run_op("R7", 1, 1, 0, 0, '0, '0, 0, 16, 3, 0);
    want(0, 16); want(1, 17); want(2, 18); check_hand("R7");
    // R8 sparse copy, source side and destination side
    run_op("R8", 1, 1, 1, 0, 16'b101, '0, 0, 16, 3, 0);
    want(0, 16); want(2, 17); check_hand("R8");
    run_op("R8 dst", 1, 1, 0, 1, '0, 16'b110, 0, 16, 3, 0);
    want(0, 17); want(1, 18); check_hand("R8 dst");
    // R9 gather/scatter
    run_op("R9", 1, 1, 1, 1, 16'b0110, 16'b1001, 8, 16, 4, 0);
    want(9, 16); want(10, 19); check_hand("R9");
    // R11 vl=0, clamp, scalar-side enable ignored
    run_op("R11 vl0", 1, 1, 0, 0, '0, '0, 0, 16, 0, 0);
    check_hand("R11 vl0");
    run_op("R11 clamp", 1, 1, 0, 0, '0, '0, 0, 16, 20, 0);
    chk("R11 clamp count", log_s.size() == VMAX,
        $sformatf("%0d", log_s.size()), $sformatf("%0d", VMAX));
    run_op("R11 scalar pen", 0, 1, 1, 0, '0, '0, 2, 8, 2, 0);
    want(2, 8); want(2, 9); check_hand("R11 scalar pen");
    // R12 wrap, with R2 start-while-busy poke
    run_op("R12", 1, 1, 0, 0, '0, '0, 0, 30, 4, 1);
    want(0, 30); want(1, 31); want(2, 0); want(3, 1); check_hand("R12");
    // R13 scalar to scalar
    run_op("R13", 0, 0, 1, 1, '0, '0, 5, 7, 9, 0);
    want(5, 7); check_hand("R13");
    // R10 idle after done
    @(posedge clk); @(negedge clk);
    chk("R10 idle", !busy_o && !done_o && !xfer_valid_o,
        $sformatf("busy=%0b done=%0b", busy_o, done_o), "0 0");

    finished = 1;
    report();
  end
endmodule